// File: doc/BRIEF.md
# Temperature-Adaptive Supply and Stall Controller

This block sits beside a multi-stage pipeline whose logic has been arranged so that its slowest paths are rare and can be predicted a cycle ahead. It compares a digital die-temperature reading with two programmable limits and picks one of three supply levels through a 2-bit select code. When the supply is lowered, the block raises a global freeze that stretches any operation predicted to use a slow path to two cycles. This keeps the clock frequency unchanged at every supply level.

Each stage reports two prediction bits every cycle. The first says the stage's slowest logic will be active. The second says its next-slowest logic will be active. At the first reduced level only first-class predictions cause a stall. At the second reduced level both classes do. A hysteresis margin stops the select code from chattering near a limit. When the supply is stepped back up, a short counter holds freeze high while the regulator settles. A saturating counter accumulates freeze cycles so that the throughput cost can be measured.

Top module: `thermal_stall_ctrl`

## Requirements
- R1: The level rises in the cycle after the temperature input reaches a limit, with reaching meaning greater than or equal. From any level, reaching the upper limit selects the second reduced level. From nominal, reaching only the lower limit selects the first reduced level.
- R2: The select code is 2'b00 for nominal, 2'b01 for the first reduced level and 2'b10 for the second reduced level. The code 2'b11 is never driven.
- R3: The level falls only when temperature plus the hysteresis margin is strictly below the limit concerned. From the second reduced level it falls to the first reduced level when temperature plus margin is still at or above the lower limit, and to nominal otherwise.
- R4: At nominal, with no settling hold running, predictions have no effect and freeze stays low.
- R5: At the first reduced level, a primary prediction from any stage raises freeze in the same cycle. Secondary predictions are ignored at this level.
- R6: At the second reduced level, a primary or a secondary prediction from any stage raises freeze in the same cycle.
- R7: A prediction-driven freeze lasts exactly one cycle. A prediction held across that freeze cycle does not freeze the following cycle. It can freeze again in the cycle after that.
- R8: Each step of the level toward nominal holds freeze high for HOLD_CYC cycles, starting in the cycle the new code appears and independent of predictions. A further downward step during the hold restarts the full count.
- R9: A step of the level away from nominal raises no freeze by itself.
- R10: The stall count rises by one after each cycle in which freeze is high, stays unchanged after cycles with freeze low, saturates at its maximum and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TEMP_W | Current die-temperature reading |
| thr_lo | input | TEMP_W | Lower temperature limit |
| thr_hi | input | TEMP_W | Upper temperature limit (above thr_lo) |
| hyst | input | TEMP_W | Hysteresis margin for falling levels |
| pred_pri | input | STAGES | Per-stage prediction of slowest-path activity |
| pred_sec | input | STAGES | Per-stage prediction of next-slowest-path activity |
| vsel | output | 2 | Supply level select code |
| freeze | output | 1 | Global pipeline stall |
| stall_cnt | output | CNT_W | Saturating count of freeze cycles |

## Verification
The bench builds the block with three stages, a four-cycle settling hold, an 8-bit temperature code and a 5-bit stall counter. The narrow counter lets a long run of held predictions reach saturation at 31. The four-cycle hold is short enough that a second downward step can be placed inside a running hold and the full restart observed. Limits of 104 and 110 with a margin of 3 put both hysteresis cases, staying and falling, only a few codes apart.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {
    LVL_NOM  = 2'b00,
    LVL_RED1 = 2'b01,
    LVL_RED2 = 2'b10
  } vlevel_e;
endpackage

// File: rtl/tac_level_fsm.sv
module tac_level_fsm
  import tac_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [TEMP_W-1:0] thr_lo,
  input  logic [TEMP_W-1:0] thr_hi,
  input  logic [TEMP_W-1:0] hyst,
  output vlevel_e           level_q,
  output logic              lower_req
);
  localparam int SUM_W = TEMP_W + 1;

  logic [SUM_W-1:0] temp_plus_hyst;
  logic             reach_lo, reach_hi, under_lo, under_hi;
  vlevel_e          level_d;
  logic             level_en;

  always_comb begin
    temp_plus_hyst = {1'b0, temp_code} + {1'b0, hyst};
    reach_lo = (temp_code >= thr_lo);
    reach_hi = (temp_code >= thr_hi);
    under_lo = (temp_plus_hyst < {1'b0, thr_lo});
    under_hi = (temp_plus_hyst < {1'b0, thr_hi});
  end

  always_comb begin
    level_d = level_q;
    unique case (level_q)
      LVL_NOM: begin
        if (reach_hi)      level_d = LVL_RED2;
        else if (reach_lo) level_d = LVL_RED1;
      end
      LVL_RED1: begin
        if (reach_hi)      level_d = LVL_RED2;
        else if (under_lo) level_d = LVL_NOM;
      end
      LVL_RED2: begin
        if (under_hi)      level_d = under_lo ? LVL_NOM : LVL_RED1;
      end
      default:             level_d = LVL_RED2;
    endcase
  end

  assign level_en  = (level_d != level_q);
  assign lower_req = (level_d < level_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= LVL_NOM;
    else if (level_en) level_q <= level_d;
  end
endmodule

// File: rtl/tac_pred_merge.sv
module tac_pred_merge
  import tac_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic [STAGES-1:0] pred_pri,
  input  logic [STAGES-1:0] pred_sec,
  input  vlevel_e           level,
  output logic              hit
);
  logic [STAGES:0] pri_chain;
  logic [STAGES:0] sec_chain;

  assign pri_chain[0] = 1'b0;
  assign sec_chain[0] = 1'b0;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign pri_chain[s+1] = pri_chain[s] | pred_pri[s];
    assign sec_chain[s+1] = sec_chain[s] | pred_sec[s];
  end

  logic gate_pri, gate_sec;

  always_comb begin
    gate_pri = (level != LVL_NOM);
    gate_sec = (level == LVL_RED2);
    hit = (gate_pri & pri_chain[STAGES]) | (gate_sec & sec_chain[STAGES]);
  end
endmodule

// File: rtl/tac_freeze_gen.sv
module tac_freeze_gen #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic lower_req,
  output logic freeze,
  output logic pred_frz,
  output logic hold_busy
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);
  localparam logic [HC_W-1:0] HOLD_LOAD = HC_W'(HOLD_CYC);

  logic            stretch_q, stretch_d;
  logic [HC_W-1:0] hold_q, hold_d;
  logic            hold_en;

  always_comb begin
    pred_frz  = hit & ~stretch_q;
    stretch_d = pred_frz;
    hold_busy = (hold_q != '0);
    hold_en   = lower_req | hold_busy;
    if (lower_req) hold_d = HOLD_LOAD;
    else           hold_d = hold_q - 1'b1;
    freeze    = pred_frz | hold_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stretch_q <= 1'b0;
    else        stretch_q <= stretch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/tac_stall_meter.sv
module tac_stall_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             cnt_en;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    cnt_en  = freeze & (count_q != CNT_MAX);
    count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end
endmodule

// File: rtl/thermal_stall_ctrl.sv
module thermal_stall_ctrl
  import tac_pkg::*;
#(
  parameter int STAGES   = 3,
  parameter int TEMP_W   = 8,
  parameter int HOLD_CYC = 4,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [TEMP_W-1:0] thr_lo,
  input  logic [TEMP_W-1:0] thr_hi,
  input  logic [TEMP_W-1:0] hyst,
  input  logic [STAGES-1:0] pred_pri,
  input  logic [STAGES-1:0] pred_sec,
  output logic [1:0]        vsel,
  output logic              freeze,
  output logic [CNT_W-1:0]  stall_cnt
);
  vlevel_e level;
  logic    lower_req, hit, pred_frz, hold_busy;

  tac_level_fsm #(.TEMP_W(TEMP_W)) u_level (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .thr_lo(thr_lo),
    .thr_hi(thr_hi), .hyst(hyst), .level_q(level), .lower_req(lower_req)
  );

  tac_pred_merge #(.STAGES(STAGES)) u_merge (
    .pred_pri(pred_pri), .pred_sec(pred_sec), .level(level), .hit(hit)
  );

  tac_freeze_gen #(.HOLD_CYC(HOLD_CYC)) u_freeze (
    .clk(clk), .rst_n(rst_n), .hit(hit), .lower_req(lower_req),
    .freeze(freeze), .pred_frz(pred_frz), .hold_busy(hold_busy)
  );

  tac_stall_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .count_q(stall_cnt)
  );

  assign vsel = level;
endmodule

// File: rtl/thermal_stall_ctrl_chk.sv
module thermal_stall_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       vsel,
  input logic             freeze,
  input logic [CNT_W-1:0] stall_cnt,
  input logic             pred_frz,
  input logic             hold_busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_VSEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    vsel != 2'b11);  // R2

  AST_NOM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel == 2'b00 && !hold_busy) |-> !freeze);  // R4

  AST_SINGLE_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pred_frz |=> !pred_frz);  // R7

  AST_HOLD_ON_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel < $past(vsel)) |-> (freeze && hold_busy));  // R8

  AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && stall_cnt != CNT_MAX) |=> (stall_cnt == CNT_W'($past(stall_cnt) + 1'b1)));  // R10

  AST_STALL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> $stable(stall_cnt));  // R10
endmodule

bind thermal_stall_ctrl thermal_stall_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsel(vsel), .freeze(freeze),
  .stall_cnt(stall_cnt), .pred_frz(pred_frz), .hold_busy(hold_busy)
);

// File: tb/thermal_stall_ctrl_bench.sv
module thermal_stall_ctrl_bench;
  localparam int STAGES = 3;
  localparam int TEMP_W = 8;
  localparam int HOLD   = 4;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [TEMP_W-1:0] temp_code, thr_lo, thr_hi, hyst;
  logic [STAGES-1:0] pred_pri, pred_sec;
  logic [1:0]        vsel;
  logic              freeze;
  logic [CNT_W-1:0]  stall_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  thermal_stall_ctrl #(.STAGES(STAGES), .TEMP_W(TEMP_W), .HOLD_CYC(HOLD), .CNT_W(CNT_W))
    u_thermal_stall_ctrl (
      .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .thr_lo(thr_lo),
      .thr_hi(thr_hi), .hyst(hyst), .pred_pri(pred_pri), .pred_sec(pred_sec),
      .vsel(vsel), .freeze(freeze), .stall_cnt(stall_cnt));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // advance one edge, leave inputs settled away from the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    chk("R2 reset vsel", vsel, 0);
    chk("R4 reset freeze", freeze, 0);
    chk("R10 reset stall_cnt", stall_cnt, 0);
  endtask

  task automatic t_nominal();
    int c0;
    temp_code = 8'd90; pred_pri = '1; pred_sec = '1; settle();
    c0 = stall_cnt;
    chk("R4 nominal preds ignored", freeze, 0);
    tick();
    chk("R4 nominal level kept", vsel, 0);
    chk("R10 no count without freeze", stall_cnt, c0);
    pred_pri = '0; pred_sec = '0; settle();
  endtask

  task automatic t_first_level();
    temp_code = 8'd103; tick();
    chk("R1 below lower limit stays nominal", vsel, 0);
    temp_code = 8'd104; tick();
    chk("R1 lower limit reached -> 01", vsel, 1);
    chk("R9 rise raises no freeze", freeze, 0);
    pred_sec = 3'b111; settle();
    chk("R5 secondary ignored at 01", freeze, 0);
    pred_sec = '0; pred_pri = 3'b010; settle();
    chk("R5 primary freezes at 01", freeze, 1);
    pred_pri = '0; settle();
  endtask

  task automatic t_second_level();
    temp_code = 8'd110; tick();
    chk("R1 upper limit reached -> 10", vsel, 2);
    chk("R9 rise to 10 raises no freeze", freeze, 0);
    pred_pri = 3'b100; settle();
    chk("R6 primary freezes at 10", freeze, 1);
    pred_pri = '0; tick();
    pred_sec = 3'b001; settle();
    chk("R6 secondary freezes at 10", freeze, 1);
    tick();
    chk("R7 held prediction not frozen twice", freeze, 0);
    tick();
    chk("R7 held prediction freezes again", freeze, 1);
    pred_sec = '0; tick();
    chk("R7 freeze clears without prediction", freeze, 0);
  endtask

  task automatic t_hyst_and_hold();
    int c0;
    temp_code = 8'd108; tick();
    chk("R3 within margin stays at 10", vsel, 2);
    chk("R3 no freeze while staying", freeze, 0);
    c0 = stall_cnt;
    temp_code = 8'd106; tick();
    chk("R3 fall from 10 to 01", vsel, 1);
    for (int i = 0; i < HOLD; i++) begin
      chk($sformatf("R8 hold cycle %0d", i), freeze, 1);
      tick();
    end
    chk("R8 hold ends after HOLD_CYC", freeze, 0);
    chk("R10 stall count +HOLD_CYC", stall_cnt, c0 + HOLD);
  endtask

  task automatic t_restart();
    temp_code = 8'd110; tick();
    chk("R1 back to 10", vsel, 2);
    temp_code = 8'd106; tick();
    chk("R8 first drop holds", freeze, 1);
    tick();
    temp_code = 8'd100; tick();
    chk("R3 fall from 01 to nominal", vsel, 0);
    for (int i = 0; i < HOLD; i++) begin
      chk($sformatf("R8 restarted hold cycle %0d", i), freeze, 1);
      tick();
    end
    chk("R8 restarted hold ends", freeze, 0);
  endtask

  task automatic t_direct_drop();
    temp_code = 8'd120; tick();
    chk("R1 nominal straight to 10", vsel, 2);
    temp_code = 8'd50; tick();
    chk("R3 10 straight to nominal", vsel, 0);
    chk("R8 hold on direct drop", freeze, 1);
    for (int i = 0; i < HOLD; i++) tick();
    chk("R8 direct drop hold ends", freeze, 0);
  endtask

  task automatic t_saturate();
    temp_code = 8'd115; tick();
    pred_pri = 3'b001;
    for (int i = 0; i < 80; i++) tick();
    pred_pri = '0; tick();
    chk("R10 stall count saturates", stall_cnt, 31);
    chk("R2 code at second level", vsel, 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    temp_code = '0; thr_lo = 8'd104; thr_hi = 8'd110; hyst = 8'd3;
    pred_pri = '0; pred_sec = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    t_reset();
    t_nominal();
    t_first_level();
    t_second_level();
    t_hyst_and_hold();
    t_restart();
    t_direct_drop();
    t_saturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule